// File: doc/BRIEF.md
# Arithmetic Right Shift Unit with Flags

This unit divides a signed operand by 2, 4, 8 or 16 with an arithmetic right shift, and it produces the condition flags for that operation. It takes a 20-bit operand, a 2-bit shift-count code, a width select and a valid strobe. The count code k selects a shift of k+1 places, so a shift of zero cannot be requested. In the full 20-bit width, bit 19 is the sign. In the 16-bit word width, bit 15 is the sign, operand bits 19:16 are ignored, and result bits 19:16 are forced to zero.

The shift and the flag logic are combinational. A register captures the result and the flags on the clock edge that samples the valid strobe. The unit then raises a one-cycle result-valid pulse. Between strobes the outputs hold their last values. An execution stage uses the unit by presenting one operation per strobe and taking the result when the pulse appears.

Top module: `sra_flag_unit`

## Requirements
- R1: The count code `shift_code` value k (0..3) selects a shift of k+1 bit positions (code 0 = 1, code 3 = 4).
- R2: With `word_sel`=0, `result` equals the 20-bit two's-complement operand divided by 2^(k+1), rounded toward negative infinity. Bit 19 is the sign and is copied into every vacated upper position.
- R3: With `word_sel`=1, `result[15:0]` equals `operand[15:0]`, taken as a signed 16-bit value and divided by 2^(k+1) with the same rounding, and `result[19:16]` is 0.
- R4: With `word_sel`=1, `operand[19:16]` has no effect on `result` or on any flag.
- R5: `flag_c` equals operand bit k, which is the last bit shifted out.
- R6: `flag_n` equals the result sign: `result[19]` with `word_sel`=0, `result[15]` with `word_sel`=1.
- R7: `flag_z` is 1 exactly when the active width of the result is zero (bits 19:0 with `word_sel`=0, bits 15:0 with `word_sel`=1).
- R8: `flag_v` is always 0.
- R9: `out_valid` is high for exactly the one cycle after each cycle in which `in_valid` is high, and `result` and all flags change only on that edge. Otherwise they hold.
- R10: After reset, `result`, all flags and `out_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation strobe |
| operand | input | 20 | Value to shift |
| shift_code | input | 2 | Shift count minus one |
| word_sel | input | 1 | 1 = 16-bit word width, 0 = 20-bit width |
| out_valid | output | 1 | One-cycle pulse when a new result is present |
| result | output | 20 | Shifted value |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag, the last bit shifted out |
| flag_v | output | 1 | Overflow flag, always 0 |

## Verification
Every count code is applied in both widths to the most negative value, -1, 0 and the most positive value. These inputs show whether sign copying is correct and whether rounding goes toward negative infinity rather than toward zero: for example, -1 must stay -1. Random operands with random counts check the division and the carry against a bench model built on integer floor division and the remainder. Word-width operations carry random garbage in bits 19:16, so any leak of those bits into the result or the flags shows up. Idle cycles between strobes confirm that the outputs hold and that the valid pulse lasts a single cycle.

// File: rtl/sra_pkg.sv
package sra_pkg;
  parameter int unsigned DATA_W = 20;
  parameter int unsigned WORD_W = 16;
  parameter int unsigned CNT_W  = 2;
  localparam int unsigned MAX_SHIFT = 1 << CNT_W;

  typedef enum logic {
    WIDTH_FULL = 1'b0,
    WIDTH_WORD = 1'b1
  } width_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  // Bring the active width to a full-width signed value.
  function automatic logic [DATA_W-1:0] widen(input logic [DATA_W-1:0] op,
                                              input width_e w);
    logic [DATA_W-1:0] r;
    if (w == WIDTH_WORD)
      r = {{(DATA_W-WORD_W){op[WORD_W-1]}}, op[WORD_W-1:0]};
    else
      r = op;
    return r;
  endfunction

  // Clear the bits above the active width.
  function automatic logic [DATA_W-1:0] trim(input logic [DATA_W-1:0] v,
                                             input width_e w);
    logic [DATA_W-1:0] r;
    if (w == WIDTH_WORD)
      r = {{(DATA_W-WORD_W){1'b0}}, v[WORD_W-1:0]};
    else
      r = v;
    return r;
  endfunction

  function automatic logic sign_of(input logic [DATA_W-1:0] v, input width_e w);
    return (w == WIDTH_WORD) ? v[WORD_W-1] : v[DATA_W-1];
  endfunction

  function automatic logic is_zero(input logic [DATA_W-1:0] v, input width_e w);
    return (w == WIDTH_WORD) ? (v[WORD_W-1:0] == '0) : (v == '0);
  endfunction
endpackage

// File: rtl/sra_shift_core.sv
module sra_shift_core
  import sra_pkg::*;
(
  input  logic [DATA_W-1:0] operand,
  input  logic [CNT_W-1:0]  shift_code,
  input  width_e            width,
  output logic [DATA_W-1:0] shifted,
  output logic              carry_out
);
  logic signed [DATA_W-1:0] ext_op;
  logic        [DATA_W-1:0] cand [MAX_SHIFT];
  logic                     cout [MAX_SHIFT];

  assign ext_op = $signed(widen(operand, width));

  // One candidate per legal count; the count code picks one.
  for (genvar g = 0; g < MAX_SHIFT; g++) begin : g_cand
    assign cand[g] = ext_op >>> (g + 1);
    assign cout[g] = ext_op[g];
  end

  assign shifted   = trim(cand[shift_code], width);
  assign carry_out = cout[shift_code];
endmodule

// File: rtl/sra_flag_gen.sv
module sra_flag_gen
  import sra_pkg::*;
(
  input  logic [DATA_W-1:0] shifted,
  input  logic              carry_in,
  input  width_e            width,
  output flags_t            flags
);
  always_comb begin
    flags.n = sign_of(shifted, width);
    flags.z = is_zero(shifted, width);
    flags.c = carry_in;
    flags.v = 1'b0;
  end
endmodule

// File: rtl/sra_out_reg.sv
module sra_out_reg
  import sra_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] d_result,
  input  flags_t            d_flags,
  input  width_e            d_width,
  output logic [DATA_W-1:0] q_result,
  output flags_t            q_flags,
  output width_e            q_width,
  output logic              q_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_result <= '0;
      q_flags  <= '0;
      q_width  <= WIDTH_FULL;
      q_valid  <= 1'b0;
    end else begin
      q_valid <= load;
      if (load) begin
        q_result <= d_result;
        q_flags  <= d_flags;
        q_width  <= d_width;
      end
    end
  end

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q_result) && $stable(q_flags));
endmodule

// File: rtl/sra_flag_unit.sv
module sra_flag_unit
  import sra_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [19:0]       operand,
  input  logic [1:0]        shift_code,
  input  logic              word_sel,
  output logic              out_valid,
  output logic [19:0]       result,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_v
);
  width_e            width_in;
  logic [DATA_W-1:0] shifted;
  logic              shift_carry;
  flags_t            flags_next;
  flags_t            flags_q;
  width_e            width_q;

  assign width_in = word_sel ? WIDTH_WORD : WIDTH_FULL;

  sra_shift_core u_core (
    .operand    (operand),
    .shift_code (shift_code),
    .width      (width_in),
    .shifted    (shifted),
    .carry_out  (shift_carry)
  );

  sra_flag_gen u_flags (
    .shifted  (shifted),
    .carry_in (shift_carry),
    .width    (width_in),
    .flags    (flags_next)
  );

  sra_out_reg u_oreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (in_valid),
    .d_result (shifted),
    .d_flags  (flags_next),
    .d_width  (width_in),
    .q_result (result),
    .q_flags  (flags_q),
    .q_width  (width_q),
    .q_valid  (out_valid)
  );

  assign flag_n = flags_q.n;
  assign flag_z = flags_q.z;
  assign flag_c = flags_q.c;
  assign flag_v = flags_q.v;

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));
  // R3
  word_upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && width_q == WIDTH_WORD) |-> result[19:16] == 4'h0);
  // R6
  neg_matches_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> flag_n == ((width_q == WIDTH_WORD) ? result[15] : result[19]));
  // R7
  zero_matches_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> flag_z == ((width_q == WIDTH_WORD) ? (result[15:0] == 16'h0)
                                                     : (result == 20'h0)));
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_v);
endmodule

// File: tb/sra_flag_unit_bench.sv
`timescale 1ns/1ps
module sra_flag_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [19:0] operand = '0;
  logic [1:0]  shift_code = '0;
  logic        word_sel = 1'b0;
  logic        out_valid;
  logic [19:0] result;
  logic        flag_n, flag_z, flag_c, flag_v;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sra_flag_unit u_sra_flag_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
    .shift_code(shift_code), .word_sel(word_sel), .out_valid(out_valid),
    .result(result), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
    .flag_v(flag_v)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Signed value of the active width, as the bench sees it.
  function automatic int active_val(input logic [19:0] op, input bit word);
    if (word) return int'($signed(op[15:0]));
    return int'($signed(op));
  endfunction

  function automatic int floor_div(input int v, input int d);
    int q;
    q = v / d;
    if (v < 0 && (v % d) != 0) q = q - 1;
    return q;
  endfunction

  task automatic run_op(input logic [19:0] op, input logic [1:0] code,
                        input bit word);
    int s, d, v, q, rem;
    logic [19:0] exp_res;
    bit exp_n, exp_z, exp_c;
    s = int'(code) + 1;                 // R1
    d = 1 << s;
    v = active_val(op, word);
    q = floor_div(v, d);
    rem = v - q * d;                    // 0..d-1: the bits shifted out
    if (word) begin
      exp_res = {4'h0, 16'(q)};         // R3
      exp_n = (q < 0);
    end else begin
      exp_res = 20'(q);                 // R2
      exp_n = (q < 0);
    end
    exp_z = (q == 0);
    exp_c = rem[s-1];                   // R5
    @(negedge clk);
    operand = op; shift_code = code; word_sel = word; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(word ? "R3/R4" : "R2", "result", 32'(result), 32'(exp_res));
    check("R6", "flag_n", 32'(flag_n), 32'(exp_n));
    check("R7", "flag_z", 32'(flag_z), 32'(exp_z));
    check("R5", "flag_c", 32'(flag_c), 32'(exp_c));
    check("R8", "flag_v", 32'(flag_v), 32'h0);
    check("R9", "out_valid pulse", 32'(out_valid), 32'h1);
    // Change the inputs while idle: nothing may move.
    operand = ~op; shift_code = ~code; word_sel = ~word;
    @(negedge clk);
    check("R9", "out_valid drop", 32'(out_valid), 32'h0);
    check("R9", "result hold", 32'(result), 32'(exp_res));
  endtask

  initial begin
    int seed_init;
    logic [19:0] edges [8];
    seed_init = $urandom(32'h5eed_0001);
    #12;
    check("R10", "reset result", 32'(result), 32'h0);
    check("R10", "reset flags", 32'({flag_n, flag_z, flag_c, flag_v}), 32'h0);
    check("R10", "reset out_valid", 32'(out_valid), 32'h0);
    rst_n = 1'b1;
    edges[0] = 20'h80000; edges[1] = 20'hFFFFF; edges[2] = 20'h00000;
    edges[3] = 20'h7FFFF; edges[4] = 20'h08000; edges[5] = 20'h0FFFF;
    edges[6] = 20'h07FFF; edges[7] = 20'h00001;
    // Directed corners: every count, both widths (R1).
    for (int e = 0; e < 8; e++)
      for (int c = 0; c < 4; c++)
        for (int w = 0; w < 2; w++)
          run_op(edges[e], 2'(c), bit'(w));
    // R4: word width with garbage above bit 15.
    for (int g = 0; g < 16; g++)
      run_op({4'(g), 16'h8001}, 2'(g), 1'b1);
    // Random mix.
    for (int i = 0; i < 400; i++)
      run_op(20'($urandom), 2'($urandom), bit'($urandom));
    // Back-to-back strobes.
    @(negedge clk);
    operand = 20'hFFFF0; shift_code = 2'd3; word_sel = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    check("R2", "b2b first", 32'(result), 32'hFFFFF);
    operand = 20'h00010; shift_code = 2'd0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", "b2b second", 32'(result), 32'h00008);
    check("R9", "b2b valid", 32'(out_valid), 32'h1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule